// File: doc/BRIEF.md
# Code Execution Watchdog

This block watches that software runs through an expected path at the expected pace. Two mechanisms run side by side while the block is active. The first is a down-counting execution timer that must be refreshed before it expires. The second is a secret tally. Software moves the tally along its path by adding or subtracting amounts. At chosen points it asks the hardware to compare the tally with the value that the path should have produced. A wrong value, a late refresh or an access at the wrong moment is a fault.

Each of six fault kinds has a three-bit action selector in the configuration register. The selector chooses no action, an interrupt request or a reset request. Every fault kind also has a sticky flag. The outputs follow the flags that are pending and the actions those flags select. Software reaches the registers through a simple single-cycle bus. Each write or read is one clock cycle, at a word offset. Two inputs can hold the timer still: one is active while interrupt handling runs, the other while a debugger has the core halted. Each freeze has its own enable bit.

Register offsets: 0 configuration, 1 fault flags, 2 keep-word, 3 seed (load tally and start), 4 period (timer reload), 5 close (final compare and stop), 6 checkpoint, 7 increase by data, 8/9/10 increase by 1/16/256, 11 decrease by data, 12/13/14 decrease by 1/16/256. Offset 15 and above are unmapped. Reads return the configuration, the flags, the keep-word and the period. All other offsets read as zero.

Top module: `code_watchdog`

## Requirements
- R1: A write to seed while idle loads the tally with the written data, loads the timer from period and makes the block active. A write to seed while active changes nothing except the sequence flag.
- R2: A write to close while active compares the data with the tally, sets the miscompare flag on a mismatch and returns the block to idle. A write to close while idle sets the sequence flag.
- R3: A write to checkpoint while active compares like close and reloads the timer from period, and the block stays active. A write to checkpoint while idle sets the sequence flag.
- R4: The increase and decrease offsets change the tally by the written data. Offsets 8/9/10 add 1/16/256 and offsets 12/13/14 subtract 1/16/256, whatever data is written. Any of them while idle sets the sequence flag and leaves the tally unchanged.
- R5: While active, the timer decreases by one each cycle. The first cycle that finds it at zero sets the timeout flag and returns the block to idle. With period P, the flag appears P+1 cycles after the seed cycle.
- R6: The timer holds its value while irq_busy is high if configuration bit 18 is set. It also holds while dbg_halt is high if bit 19 is set. With the enable bit clear, the matching input has no effect.
- R7: The configuration reads as zero while the block is active. A configuration write while active sets the control flag and leaves the register unchanged.
- R8: The configuration holds six action fields: timeout [2:0], miscompare [5:3], sequence [8:6], control [11:9], state [14:12], address [17:15]. Codes are 1 = none, 2 = interrupt, 4 = reset request. The reset value is 0x9249. A write carrying any other code sets the state flag and is rejected.
- R9: Configuration bit 20 locks the register. Once it is set, configuration writes are ignored without a fault until reset.
- R10: The flags register holds sticky bits: timeout 0, miscompare 1, sequence 2, control 3, state 4, address 5 and power-on 6. After reset it reads 0x40. A flags write clears every bit whose data bit is 0 while unlocked, or whose data bit is 1 while locked. A fault arriving in the same cycle still sets its flag.
- R11: irq_req is high while any pending flag has action code 2. rst_req is high while any pending flag has action code 4. The outputs follow the current configuration at once.
- R12: A read or write at offset 15 or above sets the address flag.
- R13: The keep-word is a 32-bit register that resets to zero and changes only by a write to its offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| bus_wr | input | 1 | write strobe, one cycle per write |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | ADDR_W | word offset |
| bus_wdata | input | DATA_W | write data |
| bus_rdata | output | DATA_W | read data, combinational from bus_addr |
| irq_busy | input | 1 | interrupt handling in progress |
| dbg_halt | input | 1 | core halted by debugger |
| irq_req | output | 1 | interrupt request |
| rst_req | output | 1 | reset request |

## Verification
The hardest situations to reach are the exact cycle at which the timer expires, and a timer held frozen across many cycles. Neither the tally nor the timer can be read. The stimulus therefore sets a small period, counts idle cycles after the seed write, and samples the flags on both sides of the expiry edge. It infers active or idle from whether the configuration reads as zero. The tally is exposed only through compares, so each arithmetic sequence ends in a close whose data is the value computed by hand. The absence of a miscompare flag is the proof that the tally was right.

// File: rtl/code_watchdog.sv
module code_watchdog #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter int ACT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_busy,
  input  logic              dbg_halt,
  output logic              irq_req,
  output logic              rst_req
);
  localparam int NFLT  = 6;
  localparam int NFLAG = NFLT + 1;
  localparam int CFG_W = NFLT * ACT_W + 3;
  localparam int B_PAUSE = NFLT * ACT_W;
  localparam int B_HALT  = B_PAUSE + 1;
  localparam int B_LOCK  = B_PAUSE + 2;

  localparam logic [ADDR_W-1:0] A_CFG   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_KEEP  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SEED  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_PER   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CLOSE = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_CHK   = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_INC   = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_INC1  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_INC16 = ADDR_W'(9);
  localparam logic [ADDR_W-1:0] A_INC256= ADDR_W'(10);
  localparam logic [ADDR_W-1:0] A_DEC   = ADDR_W'(11);
  localparam logic [ADDR_W-1:0] A_DEC1  = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_DEC16 = ADDR_W'(13);
  localparam logic [ADDR_W-1:0] A_DEC256= ADDR_W'(14);
  localparam logic [ADDR_W-1:0] A_LAST  = A_DEC256;

  localparam logic [ACT_W-1:0] ACT_NONE = ACT_W'(1);
  localparam logic [ACT_W-1:0] ACT_IRQ  = ACT_W'(2);
  localparam logic [ACT_W-1:0] ACT_RST  = ACT_W'(4);

  logic              active;
  logic [DATA_W-1:0] tally, tally_d, tmr, period, keep;
  logic [CFG_W-1:0]  cfg;
  logic [NFLAG-1:0]  flags, flags_d;
  logic [NFLT-1:0]   fault, new_ok, cur_ok, irq_v, rst_v;

  wire wr_cfg   = bus_wr && bus_addr == A_CFG;
  wire wr_flags = bus_wr && bus_addr == A_FLAGS;
  wire op_seed  = bus_wr && bus_addr == A_SEED;
  wire op_close = bus_wr && bus_addr == A_CLOSE;
  wire op_chk   = bus_wr && bus_addr == A_CHK;
  wire op_arith = bus_wr && bus_addr >= A_INC && bus_addr <= A_DEC256;
  wire locked   = cfg[B_LOCK];
  wire frozen   = (cfg[B_PAUSE] && irq_busy) || (cfg[B_HALT] && dbg_halt);

  for (genvar g = 0; g < NFLT; g++) begin : g_act
    wire [ACT_W-1:0] wf = bus_wdata[g*ACT_W +: ACT_W];
    wire [ACT_W-1:0] cf = cfg[g*ACT_W +: ACT_W];
    assign new_ok[g] = wf == ACT_NONE || wf == ACT_IRQ || wf == ACT_RST;
    assign cur_ok[g] = cf == ACT_NONE || cf == ACT_IRQ || cf == ACT_RST;
    assign irq_v[g]  = flags[g] && cf == ACT_IRQ;
    assign rst_v[g]  = flags[g] && cf == ACT_RST;
  end

  assign fault[0] = active && !frozen && tmr == '0;
  assign fault[1] = active && (op_close || op_chk) && bus_wdata != tally;
  assign fault[2] = (op_seed && active) || ((op_close || op_chk || op_arith) && !active);
  assign fault[3] = wr_cfg && active;
  assign fault[4] = wr_cfg && !active && !locked && !(&new_ok);
  assign fault[5] = (bus_wr || bus_rd) && bus_addr > A_LAST;

  assign irq_req = |irq_v;
  assign rst_req = |rst_v;

  always_comb begin
    tally_d = tally;
    if (op_seed && !active) tally_d = bus_wdata;
    else if (active && bus_wr) begin
      case (bus_addr)
        A_INC:    tally_d = tally + bus_wdata;
        A_INC1:   tally_d = tally + DATA_W'(1);
        A_INC16:  tally_d = tally + DATA_W'(16);
        A_INC256: tally_d = tally + DATA_W'(256);
        A_DEC:    tally_d = tally - bus_wdata;
        A_DEC1:   tally_d = tally - DATA_W'(1);
        A_DEC16:  tally_d = tally - DATA_W'(16);
        A_DEC256: tally_d = tally - DATA_W'(256);
        default:  tally_d = tally;
      endcase
    end
  end

  always_comb begin
    flags_d = flags;
    if (wr_flags)
      flags_d = locked ? (flags & ~bus_wdata[NFLAG-1:0]) : (flags & bus_wdata[NFLAG-1:0]);
    flags_d = flags_d | {1'b0, fault};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      tally  <= '0;
      tmr    <= '0;
      period <= '0;
      keep   <= '0;
      cfg    <= CFG_W'(21'h9249);
      flags  <= NFLAG'(7'h40);
    end else begin
      tally <= tally_d;
      flags <= flags_d;
      if (bus_wr && bus_addr == A_PER) period <= bus_wdata;
      if (bus_wr && bus_addr == A_KEEP) keep <= bus_wdata;
      if (wr_cfg && !active && !locked && (&new_ok)) cfg <= bus_wdata[CFG_W-1:0];
      if (op_seed && !active) begin
        active <= 1'b1;
        tmr    <= period;
      end else if (active) begin
        if ((op_close) || fault[0]) active <= 1'b0;
        if (op_chk) tmr <= period;
        else if (!frozen && tmr != '0) tmr <= tmr - DATA_W'(1);
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = active ? '0 : DATA_W'(cfg);
      A_FLAGS: bus_rdata = DATA_W'(flags);
      A_KEEP:  bus_rdata = keep;
      A_PER:   bus_rdata = period;
      default: bus_rdata = '0;
    endcase
  end

  assert_seed_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_seed && !active) |=> (active && tally == $past(bus_wdata) && tmr == $past(period)));
  assert_seed_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_seed && active) |=> (active && tally == $past(tally)));
  assert_close_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_close && active) |=> !active);
  assert_chk_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_chk && active) |=> tmr == $past(period));
  assert_idle_tally_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !op_seed) |=> $stable(tally));
  assert_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !frozen && tmr == '0) |=> (flags[0] && !active));
  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && frozen && !op_chk) |=> $stable(tmr));
  assert_cfg_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> $stable(cfg));
  assert_cfg_codes_R8: assert property (@(posedge clk) disable iff (!rst_n) &cur_ok);
  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> (locked && $stable(cfg)));
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> ((flags & $past(flags)) == $past(flags)));
  assert_out_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req || rst_req) |-> (|flags[NFLT-1:0]));
  assert_addr_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_wr || bus_rd) && bus_addr > A_LAST) |=> flags[5]);
  assert_keep_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_KEEP) |=> $stable(keep));
endmodule

// File: tb/test_code_watchdog.sv
module test_code_watchdog;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_busy = 1'b0, dbg_halt = 1'b0, irq_req, rst_req;
  int checks = 0, failures = 0;

  localparam logic [31:0] CFG_RST = 32'h9249;
  localparam logic [31:0] CFG_MAP = 32'h9254;

  always #5 clk = ~clk;

  code_watchdog i_code_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_busy(irq_busy),
    .dbg_halt(dbg_halt), .irq_req(irq_req), .rst_req(rst_req));

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic expect_reg(input string what, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(what, v, exp);
  endtask

  task automatic t_reset_state();
    expect_reg("R10 power-on flags", 4'd1, 32'h40);
    expect_reg("R8 config reset value", 4'd0, CFG_RST);
    expect_reg("R13 keep-word reset", 4'd2, 32'h0);
    chk("R11 irq_req at reset", {31'b0, irq_req}, 32'h0);
    chk("R11 rst_req at reset", {31'b0, rst_req}, 32'h0);
    wr(4'd1, 32'h0);
    expect_reg("R10 unlocked clear with zeros", 4'd1, 32'h0);
  endtask

  task automatic t_arith();
    wr(4'd4, 32'd1000);
    wr(4'd3, 32'd100);
    expect_reg("R7 config reads zero while active", 4'd0, 32'h0);
    wr(4'd7, 32'd5);
    wr(4'd8, 32'hFFFF_FFFF);
    wr(4'd9, 32'h1234);
    wr(4'd10, 32'h0);
    wr(4'd11, 32'd8);
    wr(4'd12, 32'h55);
    wr(4'd13, 32'hAA);
    wr(4'd14, 32'h7);
    wr(4'd5, 32'd97);
    expect_reg("R4 tally after add/sub steps matches", 4'd1, 32'h0);
    expect_reg("R2 close returns to idle", 4'd0, CFG_RST);
  endtask

  task automatic t_compare();
    wr(4'd3, 32'd7);
    wr(4'd6, 32'd8);
    expect_reg("R3 checkpoint mismatch flag", 4'd1, 32'h02);
    expect_reg("R3 stays active after checkpoint", 4'd0, 32'h0);
    wr(4'd6, 32'd7);
    wr(4'd5, 32'd7);
    expect_reg("R2 matching close adds no flag", 4'd1, 32'h02);
    wr(4'd1, 32'h0);
    wr(4'd3, 32'd7);
    wr(4'd5, 32'd9);
    expect_reg("R2 close mismatch flag", 4'd1, 32'h02);
    expect_reg("R2 idle after mismatched close", 4'd0, CFG_RST);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_reload();
    wr(4'd4, 32'd6);
    wr(4'd3, 32'd1);
    idle(4);
    wr(4'd6, 32'd1);
    idle(4);
    expect_reg("R3 checkpoint reloads timer", 4'd1, 32'h0);
    wr(4'd5, 32'd1);
    expect_reg("R3 no fault across reload", 4'd1, 32'h0);
  endtask

  task automatic t_timeout();
    wr(4'd4, 32'd5);
    wr(4'd3, 32'd3);
    idle(5);
    expect_reg("R5 no timeout one cycle early", 4'd1, 32'h0);
    expect_reg("R5 timeout at P+1", 4'd1, 32'h01);
    expect_reg("R5 idle after timeout", 4'd0, CFG_RST);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_freeze();
    wr(4'd0, CFG_RST | 32'h4_0000);
    wr(4'd4, 32'd3);
    irq_busy = 1'b1;
    wr(4'd3, 32'd0);
    idle(20);
    expect_reg("R6 pause holds timer", 4'd1, 32'h0);
    irq_busy = 1'b0;
    idle(10);
    expect_reg("R6 timer resumes after pause", 4'd1, 32'h01);
    wr(4'd1, 32'h0);
    wr(4'd0, CFG_RST | 32'h8_0000);
    dbg_halt = 1'b1;
    wr(4'd3, 32'd0);
    idle(20);
    expect_reg("R6 debug halt holds timer", 4'd1, 32'h0);
    dbg_halt = 1'b0;
    idle(10);
    expect_reg("R6 timer resumes after halt", 4'd1, 32'h01);
    wr(4'd1, 32'h0);
    wr(4'd0, CFG_RST);
    irq_busy = 1'b1;
    wr(4'd3, 32'd0);
    idle(10);
    expect_reg("R6 pause disabled has no effect", 4'd1, 32'h01);
    irq_busy = 1'b0;
    wr(4'd1, 32'h0);
  endtask

  task automatic t_sequence();
    wr(4'd4, 32'd1000);
    wr(4'd8, 32'h0);
    expect_reg("R4 step while idle is sequence fault", 4'd1, 32'h04);
    wr(4'd1, 32'h0);
    wr(4'd5, 32'd0);
    expect_reg("R2 close while idle is sequence fault", 4'd1, 32'h04);
    wr(4'd1, 32'h0);
    wr(4'd6, 32'd0);
    expect_reg("R3 checkpoint while idle is sequence fault", 4'd1, 32'h04);
    wr(4'd1, 32'h0);
    wr(4'd3, 32'd10);
    wr(4'd3, 32'd50);
    expect_reg("R1 seed while active is sequence fault", 4'd1, 32'h04);
    wr(4'd5, 32'd10);
    expect_reg("R1 second seed left tally unchanged", 4'd1, 32'h04);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_control();
    wr(4'd3, 32'd0);
    wr(4'd0, CFG_MAP);
    expect_reg("R7 config write while active faults", 4'd1, 32'h08);
    wr(4'd5, 32'd0);
    expect_reg("R7 config unchanged by active write", 4'd0, CFG_RST);
    wr(4'd1, 32'h0);
    wr(4'd0, 32'h924B);
    expect_reg("R8 invalid action code is state fault", 4'd1, 32'h10);
    expect_reg("R8 invalid write rejected", 4'd0, CFG_RST);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_outputs();
    logic [31:0] v;
    wr(4'd0, CFG_MAP);
    wr(4'd3, 32'd5);
    wr(4'd6, 32'd6);
    chk("R11 miscompare drives irq_req", {31'b0, irq_req}, 32'h1);
    chk("R11 miscompare leaves rst_req low", {31'b0, rst_req}, 32'h0);
    wr(4'd5, 32'd5);
    wr(4'd4, 32'd2);
    wr(4'd3, 32'd5);
    idle(10);
    chk("R11 timeout drives rst_req", {31'b0, rst_req}, 32'h1);
    wr(4'd1, 32'h0);
    chk("R11 outputs drop with flags", {30'b0, irq_req, rst_req}, 32'h0);
    wr(4'd0, CFG_RST);
    rd(4'd15, v);
    expect_reg("R12 unmapped read sets address flag", 4'd1, 32'h20);
    chk("R11 no-action flag keeps irq_req low", {31'b0, irq_req}, 32'h0);
    wr(4'd0, 32'h11249);
    chk("R11 output follows new mapping", {31'b0, irq_req}, 32'h1);
    wr(4'd1, 32'h20);
    expect_reg("R10 unlocked write of one keeps flag", 4'd1, 32'h20);
    wr(4'd1, 32'h0);
    expect_reg("R10 unlocked write of zero clears flag", 4'd1, 32'h0);
    wr(4'd0, CFG_RST);
    wr(4'd15, 32'h1);
    expect_reg("R12 unmapped write sets address flag", 4'd1, 32'h20);
    wr(4'd1, 32'h0);
  endtask

  task automatic t_keep();
    wr(4'd2, 32'hCAFE_F00D);
    expect_reg("R13 keep-word write", 4'd2, 32'hCAFE_F00D);
    wr(4'd3, 32'd1);
    wr(4'd5, 32'd2);
    wr(4'd1, 32'h0);
    expect_reg("R13 keep-word survives run and fault", 4'd2, 32'hCAFE_F00D);
  endtask

  task automatic t_lock();
    logic [31:0] v;
    wr(4'd0, CFG_RST | 32'h10_0000);
    expect_reg("R9 lock bit set", 4'd0, 32'h10_9249);
    wr(4'd0, CFG_MAP);
    expect_reg("R9 locked config ignores write", 4'd0, 32'h10_9249);
    expect_reg("R9 ignored write raises no fault", 4'd1, 32'h0);
    rd(4'd15, v);
    wr(4'd1, 32'h0);
    expect_reg("R10 locked write of zero keeps flag", 4'd1, 32'h20);
    wr(4'd1, 32'h20);
    expect_reg("R10 locked write of one clears flag", 4'd1, 32'h0);
    do_reset();
    expect_reg("R9 reset clears lock", 4'd0, CFG_RST);
    expect_reg("R13 reset clears keep-word", 4'd2, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset_state();
    t_arith();
    t_compare();
    t_reload();
    t_timeout();
    t_freeze();
    t_sequence();
    t_control();
    t_outputs();
    t_keep();
    t_lock();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule